// File: doc/BRIEF.md
# Reset Cause Aggregation Controller

This block collects up to 32 reset requests and turns them into one system reset with a cold/hot tag. The requests come from hardware detectors (supply droop, over-temperature, debug and scan-port requests, watchdogs) and from a software countdown. Each request is first passed through a two-flop synchronizer. Three per-source masks gate and shape it:
- an enable mask decides which sources may start a reset;
- a hold mask decides whether the reset lasts as long as the source stays active, or ends after a fixed minimum pulse;
- a kind mask marks each source as a cold or a hot reset.

A sticky cause register records which sources fired, so software can read it after the system comes back up. All configuration and cause state is cleared only by the power-on reset input, never by the reset this block drives. A 32-bit software counter decrements on an external 24 MHz tick enable. When the counter reaches 2 it raises the software source. Writing zero to the counter cancels a pending request. Software reaches everything over a simple 32-bit register bus: writes take effect on the clock edge, and read data is combinational.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After `por_rst`, every register reads 0, `sys_rst_o` is 0 and `rst_hot_o` is 0.
- R2: The implemented source positions are bits 0, 1, 4, 5, 16, 17, 24, 30 and 31 (mask 0xC1030033). All other positions read 0 in every register, and writes to them are dropped. The register offsets are:
  - 0x00: cause, write-1-to-clear
  - 0x04: live status, read-only
  - 0x08: hold mask
  - 0x0C: enable mask
  - 0x10: kind mask
  - 0x1C: software counter
  - 0x14 and 0x18 read 0.
- R3: A cause bit is set when its source starts a reset. It stays set until a 1 is written to that bit at 0x00; writing 0 leaves it unchanged. If a clear and a set of the same bit fall in the same cycle, the set wins. The bit survives the reset pulse the block generates.
- R4: Status at 0x04 shows the synchronized live level of each source, two clock edges after the raw input changes. Bit 31 is 1 exactly while the software counter equals 2.
- R5: Only a source whose enable bit is 1 starts a reset. A source starts at most one reset per assertion: it must drop before it can start another.
- R6: With the hold bit clear, `sys_rst_o` rises at the third rising edge after the raw input goes high. It then stays high for exactly MIN_PULSE cycles (default 16), even if the source is still active.
- R7: With the hold bit set for a triggering source, `sys_rst_o` stays high for at least MIN_PULSE cycles and until that source's synchronized level drops. A raw input held high for H ≥ MIN_PULSE+2 edges gives a pulse of H cycles.
- R8: `rst_hot_o` is 1 during a pulse only if every triggering source has kind bit 1; any triggering source with kind 0 makes the reset cold.
- R9: A write to 0x1C loads the counter. Otherwise each cycle with `tick_i` high decrements it, and it stops at 0. A write in the same cycle as a tick wins.
- R10: When the counter reaches 2 and bit 31 is enabled, a reset starts and cause bit 31 is set. Writing 0 before the counter reaches 2 cancels the request.
- R11: When several enabled sources start a reset in the same cycle, all of their cause bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| src_req_i | input | 31 | Raw asynchronous reset requests for source positions 0..30 |
| tick_i | input | 1 | 24 MHz timebase enable for the software counter |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (0 when not reading) |
| sys_rst_o | output | 1 | System reset request |
| rst_hot_o | output | 1 | 1 = hot reset, 0 = cold reset |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a software write-1-to-clear of the cause register and a new reset capture. The bench raises a source and issues the clearing write exactly two edges later, so both hit the register on the trigger edge. The write clears one bit that was already set and also targets the bit being captured; the bench expects the first bit to clear and the captured bit to stay set.

The second pair is a counter load and a timebase tick. The bench asserts both in one cycle and expects the loaded value unchanged on readback.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int unsigned DW    = 32;
    localparam int unsigned SRC_W = 32;
    localparam int unsigned AW    = 5;
    localparam int unsigned SW_POS = 31;

    localparam logic [SRC_W-1:0] DEF_IMPL = 32'hC103_0033;

    localparam logic [AW-1:0] OFS_CAUSE = 5'h00;
    localparam logic [AW-1:0] OFS_LIVE  = 5'h04;
    localparam logic [AW-1:0] OFS_HOLD  = 5'h08;
    localparam logic [AW-1:0] OFS_EN    = 5'h0C;
    localparam logic [AW-1:0] OFS_KIND  = 5'h10;
    localparam logic [AW-1:0] OFS_SWCNT = 5'h1C;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [SRC_W-1:0] hold;
        logic [SRC_W-1:0] en;
        logic [SRC_W-1:0] kind;
    } src_cfg_t;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_wr_t;

    // Hot only when no triggering source asks for cold.
    function automatic logic all_hot(input logic [SRC_W-1:0] fire,
                                     input logic [SRC_W-1:0] kind);
        return &(kind | ~fire);
    endfunction

    function automatic logic wr_hit(input bus_wr_t w, input logic [AW-1:0] ofs);
        return w.wr && (w.addr == ofs);
    endfunction
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int unsigned W = 31
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
    import rcc_pkg::*;
#(
    parameter logic [SRC_W-1:0] IMPL_MASK = DEF_IMPL
) (
    input  logic             clk,
    input  logic             por_rst,
    input  bus_wr_t          wr_i,
    input  logic [SRC_W-1:0] fire_i,
    input  logic             tick_i,
    output src_cfg_t         cfg_o,
    output logic [SRC_W-1:0] cause_o,
    output logic [DW-1:0]    swcnt_o
);
    src_cfg_t         cfg_q;
    logic [SRC_W-1:0] cause_q;
    logic [DW-1:0]    cnt_q;
    logic [SRC_W-1:0] clr_mask;
    logic [SRC_W-1:0] wmask;

    assign wmask    = wr_i.data[SRC_W-1:0] & IMPL_MASK;
    assign clr_mask = wr_hit(wr_i, OFS_CAUSE) ? wmask : '0;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            cfg_q   <= '0;
            cause_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_hit(wr_i, OFS_HOLD)) cfg_q.hold <= wmask;
            if (wr_hit(wr_i, OFS_EN))   cfg_q.en   <= wmask;
            if (wr_hit(wr_i, OFS_KIND)) cfg_q.kind <= wmask;
            cause_q <= (cause_q & ~clr_mask) | (fire_i & IMPL_MASK);
            if (wr_hit(wr_i, OFS_SWCNT)) begin
                cnt_q <= wr_i.data;
            end else if (tick_i && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cfg_o   = cfg_q;
    assign cause_o = cause_q;
    assign swcnt_o = cnt_q;

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        (cause_q != '0) |=> ((cause_q & $past(cause_q & ~clr_mask)) == $past(cause_q & ~clr_mask))) // R3
        else $error("cause bit lost without clear");
    AST_CAUSE_CAPTURE: assert property (@(posedge clk) disable iff (por_rst)
        (fire_i != '0) |=> ((cause_q & $past(fire_i)) == $past(fire_i))) // R11
        else $error("triggering source not recorded");
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (por_rst)
        ((cnt_q == '0) && !wr_hit(wr_i, OFS_SWCNT)) |=> (cnt_q == '0)) // R9
        else $error("counter moved below zero");
endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
    import rcc_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 16
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic [SRC_W-1:0] status_i,
    input  src_cfg_t         cfg_i,
    output logic [SRC_W-1:0] fire_o,
    output logic             sys_rst_o,
    output logic             hot_o
);
    localparam int unsigned PW = $clog2(MIN_PULSE + 1);

    seq_state_e       st_q;
    logic [PW-1:0]    len_q;
    logic [SRC_W-1:0] held_q;
    logic [SRC_W-1:0] spent_q;
    logic             hot_q;
    logic [SRC_W-1:0] cand;
    logic             held_live;

    assign cand      = status_i & cfg_i.en & ~spent_q;
    assign fire_o    = (st_q == SEQ_IDLE) ? cand : '0;
    assign held_live = |(held_q & status_i);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            st_q    <= SEQ_IDLE;
            len_q   <= '0;
            held_q  <= '0;
            spent_q <= '0;
            hot_q   <= 1'b0;
        end else begin
            spent_q <= (spent_q | fire_o) & status_i;
            unique case (st_q)
                SEQ_IDLE: begin
                    if (fire_o != '0) begin
                        st_q   <= SEQ_PULSE;
                        len_q  <= PW'(MIN_PULSE - 1);
                        held_q <= fire_o & cfg_i.hold;
                        hot_q  <= all_hot(fire_o, cfg_i.kind);
                    end
                end
                SEQ_PULSE: begin
                    if (len_q != '0) begin
                        len_q <= len_q - 1'b1;
                    end else if (held_live) begin
                        st_q <= SEQ_HOLD;
                    end else begin
                        st_q <= SEQ_IDLE;
                    end
                end
                SEQ_HOLD: begin
                    if (!held_live) st_q <= SEQ_IDLE;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign sys_rst_o = (st_q != SEQ_IDLE);
    assign hot_o     = hot_q;

    // Checker-only count of high cycles, saturating at MIN_PULSE.
    logic [PW-1:0] hi_len_q;
    always_ff @(posedge clk) begin
        if (por_rst || !sys_rst_o) hi_len_q <= '0;
        else if (hi_len_q != PW'(MIN_PULSE)) hi_len_q <= hi_len_q + 1'b1;
    end

    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (por_rst)
        $rose(sys_rst_o) |-> (|($past(status_i) & $past(cfg_i.en)))) // R5
        else $error("reset started without enabled source");
    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (por_rst)
        $fell(sys_rst_o) |-> (hi_len_q == PW'(MIN_PULSE))) // R6
        else $error("reset pulse too short");
    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst_o && held_live) |=> sys_rst_o) // R7
        else $error("reset released while held source active");
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned      MIN_PULSE = 16,
    parameter logic [SRC_W-1:0] IMPL_MASK = DEF_IMPL
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic [SRC_W-2:0] src_req_i,
    input  logic             tick_i,
    input  logic             bus_en_i,
    input  logic             bus_we_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    output logic             sys_rst_o,
    output logic             rst_hot_o
);
    logic [SRC_W-2:0] hw_sync;
    logic [SRC_W-1:0] status;
    logic [SRC_W-1:0] fire;
    logic [SRC_W-1:0] cause;
    logic [DW-1:0]    swcnt;
    src_cfg_t         cfg;
    bus_wr_t          wr;
    logic             sw_req;

    rcc_sync #(.W(SRC_W - 1)) u_sync (
        .clk    (clk),
        .por_rst(por_rst),
        .raw_i  (src_req_i),
        .sync_o (hw_sync)
    );

    assign sw_req = (swcnt == DW'(2));
    assign status = {sw_req, hw_sync} & IMPL_MASK;

    assign wr.wr   = bus_en_i && bus_we_i;
    assign wr.addr = bus_addr_i;
    assign wr.data = bus_wdata_i;

    rcc_regs #(.IMPL_MASK(IMPL_MASK)) u_regs (
        .clk    (clk),
        .por_rst(por_rst),
        .wr_i   (wr),
        .fire_i (fire),
        .tick_i (tick_i),
        .cfg_o  (cfg),
        .cause_o(cause),
        .swcnt_o(swcnt)
    );

    rcc_seq #(.MIN_PULSE(MIN_PULSE)) u_seq (
        .clk      (clk),
        .por_rst  (por_rst),
        .status_i (status),
        .cfg_i    (cfg),
        .fire_o   (fire),
        .sys_rst_o(sys_rst_o),
        .hot_o    (rst_hot_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_en_i && !bus_we_i) begin
            unique case (bus_addr_i)
                OFS_CAUSE: bus_rdata_o = cause;
                OFS_LIVE:  bus_rdata_o = status;
                OFS_HOLD:  bus_rdata_o = cfg.hold;
                OFS_EN:    bus_rdata_o = cfg.en;
                OFS_KIND:  bus_rdata_o = cfg.kind;
                OFS_SWCNT: bus_rdata_o = swcnt;
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    AST_STATUS_SW: assert property (@(posedge clk) disable iff (por_rst)
        (bus_en_i && !bus_we_i && bus_addr_i == OFS_LIVE && swcnt == DW'(2)
         && IMPL_MASK[SW_POS]) |-> bus_rdata_o[SW_POS]) // R4
        else $error("software source not visible in status");
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
    logic        clk = 1'b0;
    logic        por_rst;
    logic [30:0] src_req;
    logic        tick;
    logic        bus_en, bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        sys_rst, rst_hot;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    int    exp_w[$];
    bit    exp_h[$];
    string exp_t[$];

    always #2 clk = ~clk;

    rst_cause_ctrl u_dut (
        .clk(clk), .por_rst(por_rst), .src_req_i(src_req), .tick_i(tick),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .sys_rst_o(sys_rst), .rst_hot_o(rst_hot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input string req, input int w, input bit h);
        exp_t.push_back(req); exp_w.push_back(w); exp_h.push_back(h);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic drain();
        wait (exp_w.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: measures each reset pulse and compares against the scoreboard.
    int  hi_cnt = 0;
    bit  hot_seen = 0;
    always @(negedge clk) begin
        if (!por_rst) begin
            if (sys_rst) begin
                hi_cnt++;
                hot_seen = rst_hot;
            end else if (hi_cnt > 0) begin
                vecs++;
                if (exp_w.size() == 0) begin
                    bad++;
                    $display("FAIL R5: unexpected reset pulse width %0d expected none", hi_cnt);
                end else begin
                    string t; int w; bit h;
                    t = exp_t.pop_front(); w = exp_w.pop_front(); h = exp_h.pop_front();
                    if (hi_cnt != w || hot_seen != h) begin
                        bad++;
                        $display("FAIL %s: pulse width %0d hot %0d expected width %0d hot %0d",
                                 t, hi_cnt, hot_seen, w, h);
                    end
                end
                hi_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    localparam logic [31:0] IMPL = 32'hC103_0033;

    initial begin
        por_rst = 1; src_req = '0; tick = 0;
        bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        por_rst = 0;

        // R1: reset state
        rd_chk("R1 cause", 5'h00, 0);
        rd_chk("R1 status", 5'h04, 0);
        rd_chk("R1 hold", 5'h08, 0);
        rd_chk("R1 enable", 5'h0C, 0);
        rd_chk("R1 kind", 5'h10, 0);
        rd_chk("R1 counter", 5'h1C, 0);
        chk("R1 sys_rst", {31'b0, sys_rst}, 0);
        chk("R1 hot", {31'b0, rst_hot}, 0);

        // R2: unimplemented bits and reserved offsets
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_write(5'h10, 32'hFFFF_FFFF);
        rd_chk("R2 hold mask", 5'h08, IMPL);
        rd_chk("R2 enable mask", 5'h0C, IMPL);
        rd_chk("R2 kind mask", 5'h10, IMPL);
        bus_write(5'h14, 32'hFFFF_FFFF);
        rd_chk("R2 reserved 14", 5'h14, 0);
        rd_chk("R2 reserved 18", 5'h18, 0);
        bus_write(5'h08, 0);
        bus_write(5'h0C, 0);
        bus_write(5'h10, 0);

        // R5: disabled source is visible in status but does nothing (R4)
        @(negedge clk); src_req[0] = 1'b1; src_req[8] = 1'b1;
        repeat (6) @(negedge clk);
        rd_chk("R4 live status", 5'h04, 32'h0000_0001);
        rd_chk("R5 disabled no cause", 5'h00, 0);
        chk("R5 disabled no reset", {31'b0, sys_rst}, 0);
        @(negedge clk); src_req = '0;
        repeat (4) @(negedge clk);

        bus_write(5'h0C, IMPL);

        // R6: start edge and fixed width while source stays active
        push("R6 non-hold width", 16, 0);
        @(negedge clk); src_req[16] = 1'b1;
        @(negedge clk); chk("R6 edge1 low", {31'b0, sys_rst}, 0);
        @(negedge clk); chk("R6 edge2 low", {31'b0, sys_rst}, 0);
        @(negedge clk); chk("R6 edge3 high", {31'b0, sys_rst}, 1);
        repeat (40) @(negedge clk);
        src_req[16] = 1'b0;
        drain();
        rd_chk("R3 cause survives pulse", 5'h00, 32'h0001_0000);
        bus_write(5'h00, 32'h0000_0000);
        rd_chk("R3 write 0 keeps", 5'h00, 32'h0001_0000);
        bus_write(5'h00, 32'h0001_0000);
        rd_chk("R3 write 1 clears", 5'h00, 0);

        // R7: held source, hot kind (R8)
        bus_write(5'h08, 32'h0000_0002);
        bus_write(5'h10, 32'h0100_0012);
        push("R7 held width", 40, 1);
        @(negedge clk); src_req[1] = 1'b1;
        repeat (40) @(negedge clk);
        src_req[1] = 1'b0;
        drain();
        bus_write(5'h00, IMPL);

        // R8/R11: cold wins over hot, both causes recorded
        push("R8 cold wins", 16, 0);
        @(negedge clk); src_req[4] = 1'b1; src_req[5] = 1'b1;
        repeat (3) @(negedge clk);
        src_req = '0;
        drain();
        rd_chk("R11 both causes", 5'h00, 32'h0000_0030);
        bus_write(5'h00, IMPL);

        // R8: all-hot sources give hot reset
        push("R8 all hot", 16, 1);
        @(negedge clk); src_req[4] = 1'b1; src_req[24] = 1'b1;
        repeat (3) @(negedge clk);
        src_req = '0;
        drain();
        rd_chk("R11 hot causes", 5'h00, 32'h0100_0010);
        bus_write(5'h00, IMPL);

        // R3: clear and set on the same edge
        push("R3 preset pulse", 16, 0);
        @(negedge clk); src_req[0] = 1'b1;
        repeat (3) @(negedge clk);
        src_req = '0;
        drain();
        push("R3 same-edge pulse", 16, 0);
        @(negedge clk); src_req[17] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 5'h00; bus_wdata = 32'h0002_0001;
        @(negedge clk);
        bus_en = 0; bus_we = 0; src_req = '0;
        drain();
        rd_chk("R3 set wins over clear", 5'h00, 32'h0002_0000);
        bus_write(5'h00, IMPL);

        // R9: counter load, decrement, write-over-tick, floor
        bus_write(5'h1C, 5);
        rd_chk("R9 load", 5'h1C, 5);
        pulse_tick();
        rd_chk("R9 decrement", 5'h1C, 4);
        @(negedge clk);
        tick = 1; bus_en = 1; bus_we = 1; bus_addr = 5'h1C; bus_wdata = 9;
        @(negedge clk);
        tick = 0; bus_en = 0; bus_we = 0;
        rd_chk("R9 write beats tick", 5'h1C, 9);
        bus_write(5'h1C, 0);
        pulse_tick(); pulse_tick();
        rd_chk("R9 floor at zero", 5'h1C, 0);

        // R10: cancel before reaching 2
        bus_write(5'h1C, 4);
        pulse_tick();
        bus_write(5'h1C, 0);
        repeat (4) pulse_tick();
        repeat (20) @(negedge clk);
        rd_chk("R10 cancel no cause", 5'h00, 0);

        // R10: reaching 2 fires software reset (kind bit 31 is 0 -> cold)
        bus_write(5'h1C, 3);
        push("R10 software reset", 16, 0);
        pulse_tick();
        rd_chk("R4 status sw bit", 5'h04, 32'h8000_0000);
        drain();
        rd_chk("R10 software cause", 5'h00, 32'h8000_0000);
        repeat (3) pulse_tick();
        rd_chk("R9 stops at zero after fire", 5'h1C, 0);

        repeat (10) @(negedge clk);
        chk("R5 no stray pulses", exp_w.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule